// File: doc/BRIEF.md
# Per-Function Power-Down Manager

This block conserves power separately for each I/O function on a card that holds several of them. Each function has its own small register set. An automatic mode counts clock cycles with no host access and puts the function to sleep once a programmed limit is reached. Software can also force a function down through a power-down bit, whatever the inactivity count says. A host may also pick a reduced clock for a function that is awake: the clock can be divided or stopped completely.

A host access aimed at a sleeping function does not fail. The access wakes the function, and the manager raises a shared wait line for a programmed recovery time. The access completes in the first cycle in which wait is low. Each function's clock output is a glitch-free gated copy of the input clock. It is held low while the function sleeps or is stopped, and it lets through one pulse in every 2, 4 or 8 cycles when divided.

Top module: `fnpwr_mgr`

## Requirements
- R1: After reset every function is awake (power-down outputs low), wait is low, automatic mode and forced power-down are off, and every function clock output pulses once per input clock cycle.
- R2: With the auto bit (control bit 0) set and a timeout T other than zero, a function's power-down output rises at the clock edge that ends the T-th consecutive cycle with no access to it. With T equal to zero, or with auto clear, the function never sleeps on its own.
- R3: An access that falls in the same cycle in which the timeout would expire wins over the timeout. The function stays awake, wait stays low and the inactivity count starts again from zero.
- R4: An access to a sleeping function that is not forced down raises wait in that same cycle. The power-down output falls at the next edge. Wait then stays high for recovery+2 cycles in total, and the access proceeds in the first cycle with wait low.
- R5: Control bits 2:1 pick the clock mode: 00 gives the full clock, 01 a divided clock, 1x a stopped clock. In divide mode, bits 4:3 select the divider: 00 gives one pulse per 2 cycles, 01 one per 4, and 1x one per 8.
- R6: While a function is powered down, its clock output is held low.
- R7: Control bit 5 (forced power-down) sends the function to sleep at the next edge from any state. While the bit is set, accesses do not wake the function and wait stays low. Clearing the bit leaves the function asleep until its next access.
- R8: The register writes, accesses and state of one function have no effect on another function.
- R9: Register address 0 is control, 1 is the 16-bit timeout and 2 is the 8-bit recovery count. A write to address 3 changes nothing.
- R10: Wait is high while any function is stalling an access. When several functions wake together, wait stays high until the slowest one has recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock input, also clocks the manager |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | NUM_FN | Per-function host access strobe, held until wait is low |
| reg_wr | input | 1 | Register write strobe |
| reg_fn | input | FN_W | Function selected by the register write |
| reg_addr | input | 2 | Register address (0 control, 1 timeout, 2 recovery) |
| reg_wdata | input | TMO_W | Register write data |
| fn_clk_o | output | NUM_FN | Gated or divided clock for each function |
| fn_pd_o | output | NUM_FN | Per-function power-down indication |
| wait_o | output | 1 | Stalls the host access while a function recovers |

## Verification
Two events can fall in the same cycle: the expiry of the inactivity timeout and a fresh host access. The bench drops the access, counts idle cycles up to one cycle short of the limit, and then raises the access so that it is sampled on the very edge where sleep would occur. It then checks that the power-down output and wait both stay low, and that a full new timeout is needed afterwards. A second clash wakes two functions in the same cycle with different recovery counts. There the bench requires wait to last as long as the longer of the two recoveries.

// File: rtl/fnpwr_pkg.sv
package fnpwr_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_WAKE   = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic       force_pd;
        logic [1:0] div_sel;
        logic [1:0] clk_mode;
        logic       auto_en;
    } pm_ctrl_t;

    localparam int CTRL_W = $bits(pm_ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TMO  = 2'd1;
    localparam logic [1:0] ADDR_REC  = 2'd2;

    localparam int DIV_W = 3;

    function automatic logic mode_is_stop(input logic [1:0] mode);
        return mode[1];
    endfunction

    function automatic logic mode_is_div(input logic [1:0] mode);
        return mode == 2'b01;
    endfunction

    function automatic logic [DIV_W-1:0] div_mask(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3'b001;
            2'b01:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/fnpwr_regs.sv
module fnpwr_regs
    import fnpwr_pkg::*;
#(
    parameter int          TMO_W   = 16,
    parameter int          REC_W   = 8,
    parameter logic [TMO_W-1:0] TMO_RST = 1000,
    parameter logic [REC_W-1:0] REC_RST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [TMO_W-1:0] wdata,
    output pm_ctrl_t         ctrl_o,
    output logic [TMO_W-1:0] tmo_o,
    output logic [REC_W-1:0] rec_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            tmo_o  <= TMO_RST;
            rec_o  <= REC_RST;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL: ctrl_o <= pm_ctrl_t'(wdata[CTRL_W-1:0]);
                ADDR_TMO:  tmo_o  <= wdata;
                ADDR_REC:  rec_o  <= wdata[REC_W-1:0];
                default:   ;
            endcase
        end
    end

    p_bad_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> ($stable(ctrl_o) && $stable(tmo_o) && $stable(rec_o)));

endmodule

// File: rtl/fnpwr_fsm.sv
module fnpwr_fsm
    import fnpwr_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int REC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_i,
    input  logic             auto_i,
    input  logic             force_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic [REC_W-1:0] rec_i,
    output logic             pd_o,
    output logic             wait_o
);

    pm_state_e        state, state_n;
    logic [TMO_W-1:0] idle, idle_n;
    logic [TMO_W:0]   idle_p1;
    logic [REC_W-1:0] rcnt, rcnt_n;
    logic             tmo_hit;

    assign idle_p1 = {1'b0, idle} + 1'b1;
    assign tmo_hit = auto_i && (tmo_i != '0) && (idle_p1 >= {1'b0, tmo_i});

    always_comb begin
        state_n = state;
        idle_n  = idle;
        rcnt_n  = rcnt;
        case (state)
            PM_ACTIVE: begin
                if (force_i) begin
                    state_n = PM_SLEEP;
                    idle_n  = '0;
                end else if (acc_i || !auto_i) begin
                    idle_n = '0;
                end else if (tmo_hit) begin
                    state_n = PM_SLEEP;
                    idle_n  = '0;
                end else begin
                    idle_n = idle_p1[TMO_W-1:0];
                end
            end
            PM_SLEEP: begin
                if (acc_i && !force_i) begin
                    state_n = PM_WAKE;
                    rcnt_n  = rec_i;
                end
            end
            PM_WAKE: begin
                idle_n = '0;
                if (force_i)            state_n = PM_SLEEP;
                else if (rcnt == '0)    state_n = PM_ACTIVE;
                else                    rcnt_n  = rcnt - 1'b1;
            end
            default: state_n = PM_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PM_ACTIVE;
            idle  <= '0;
            rcnt  <= '0;
        end else begin
            state <= state_n;
            idle  <= idle_n;
            rcnt  <= rcnt_n;
        end
    end

    assign pd_o   = (state == PM_SLEEP);
    assign wait_o = acc_i && (((state == PM_SLEEP) && !force_i) || (state == PM_WAKE));

    p_force_sleeps_r7: assert property (@(posedge clk) disable iff (rst)
        force_i |=> pd_o);

    p_wake_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (pd_o && acc_i && !force_i) |=> (!pd_o && wait_o == acc_i));

    p_no_sleep_on_access_r3: assert property (@(posedge clk) disable iff (rst)
        (state == PM_ACTIVE && acc_i && !force_i) |=> !pd_o);

    p_sleep_needs_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_o) |-> $past(auto_i || force_i));

endmodule

// File: rtl/fnpwr_clkgate.sv
module fnpwr_clkgate
    import fnpwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] div_sel_i,
    output logic       fn_clk_o
);

    logic [DIV_W-1:0] div_cnt;
    logic             en_c, en_q;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        if (pd_i || mode_is_stop(mode_i))
            en_c = 1'b0;
        else if (mode_is_div(mode_i))
            en_c = ((div_cnt & div_mask(div_sel_i)) == '0);
        else
            en_c = 1'b1;
    end

    // Enable changes only while the clock is low, so the gated output never glitches.
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b1;
        else     en_q <= en_c;
    end

    assign fn_clk_o = clk & en_q;

    p_gate_low_asleep_r6: assert property (@(posedge clk) disable iff (rst)
        pd_i |-> !en_q);

    p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
        mode_is_stop(mode_i) |-> !en_q);

endmodule

// File: rtl/fnpwr_mgr.sv
module fnpwr_mgr
    import fnpwr_pkg::*;
#(
    parameter int               NUM_FN  = 2,
    parameter int               TMO_W   = 16,
    parameter int               REC_W   = 8,
    parameter logic [TMO_W-1:0] TMO_RST = 1000,
    parameter logic [REC_W-1:0] REC_RST = 4,
    localparam int              FN_W    = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_FN-1:0] acc_i,
    input  logic              reg_wr,
    input  logic [FN_W-1:0]   reg_fn,
    input  logic [1:0]        reg_addr,
    input  logic [TMO_W-1:0]  reg_wdata,
    output logic [NUM_FN-1:0] fn_clk_o,
    output logic [NUM_FN-1:0] fn_pd_o,
    output logic              wait_o
);

    logic [NUM_FN-1:0] wait_vec;

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        pm_ctrl_t         ctrl;
        logic [TMO_W-1:0] tmo;
        logic [REC_W-1:0] rec;
        logic             wr_sel;

        assign wr_sel = reg_wr && (reg_fn == FN_W'(g));

        fnpwr_regs #(
            .TMO_W  (TMO_W),
            .REC_W  (REC_W),
            .TMO_RST(TMO_RST),
            .REC_RST(REC_RST)
        ) i_regs (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .ctrl_o(ctrl),
            .tmo_o (tmo),
            .rec_o (rec)
        );

        fnpwr_fsm #(
            .TMO_W(TMO_W),
            .REC_W(REC_W)
        ) i_fsm (
            .clk    (clk),
            .rst    (rst),
            .acc_i  (acc_i[g]),
            .auto_i (ctrl.auto_en),
            .force_i(ctrl.force_pd),
            .tmo_i  (tmo),
            .rec_i  (rec),
            .pd_o   (fn_pd_o[g]),
            .wait_o (wait_vec[g])
        );

        fnpwr_clkgate i_gate (
            .clk      (clk),
            .rst      (rst),
            .pd_i     (fn_pd_o[g]),
            .mode_i   (ctrl.clk_mode),
            .div_sel_i(ctrl.div_sel),
            .fn_clk_o (fn_clk_o[g])
        );
    end

    assign wait_o = |wait_vec;

    p_wait_any_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_i == '0) |-> !wait_o);

endmodule

// File: tb/test_fnpwr_mgr.sv
module test_fnpwr_mgr;

    localparam int NF = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] acc = '0;
    logic          reg_wr = 1'b0;
    logic          reg_fn = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [NF-1:0] fn_clk;
    logic [NF-1:0] fn_pd;
    logic          wait_s;

    int checks = 0;
    int errors = 0;
    int ck_cnt0 = 0;
    int ck_cnt1 = 0;

    always #2.5 clk = ~clk;

    fnpwr_mgr #(.NUM_FN(NF)) i_fnpwr_mgr (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (acc),
        .reg_wr   (reg_wr),
        .reg_fn   (reg_fn),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .fn_clk_o (fn_clk),
        .fn_pd_o  (fn_pd),
        .wait_o   (wait_s)
    );

    always @(posedge fn_clk[0]) ck_cnt0++;
    always @(posedge fn_clk[1]) ck_cnt1++;

    // Clock-mode table: control value and expected pulses in 64 cycles (R5)
    localparam int NV = 7;
    localparam logic [5:0] V_CTRL [NV] = '{6'b000000, 6'b000010, 6'b001010,
                                           6'b010010, 6'b011010, 6'b000100, 6'b000110};
    localparam int         V_EXP  [NV] = '{64, 32, 16, 8, 8, 0, 0};

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic fn, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_fn = fn; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic window(output int c0, output int c1);
        int s0, s1;
        repeat (2) @(negedge clk);
        s0 = ck_cnt0; s1 = ck_cnt1;
        repeat (64) @(negedge clk);
        c0 = ck_cnt0 - s0; c1 = ck_cnt1 - s1;
    endtask

    task automatic wait_len(output int n);
        n = 0;
        #1;
        while (wait_s && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic sleep_len(input int fn, output int n);
        n = 0;
        while (!fn_pd[fn] && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0, c1, n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pd", int'(fn_pd), 0);
        chk("R1 wait", int'(wait_s), 0);
        window(c0, c1);
        chk("R1 clk0", c0, 64);
        chk("R1 clk1", c1, 64);

        // R5 / R8: walk the clock-mode table on function 0
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, 2'd0, {10'd0, V_CTRL[v]});
            window(c0, c1);
            chk($sformatf("R5 mode %0d", v), c0, V_EXP[v]);
            chk("R8 fn1 clock unaffected", c1, 64);
        end
        wr(1'b0, 2'd0, 16'd0);

        // R2: timeout of 5 idle cycles
        wr(1'b0, 2'd1, 16'd5);
        wr(1'b0, 2'd0, 16'd1);
        @(negedge clk); acc[0] = 1'b1;
        @(negedge clk); acc[0] = 1'b0;
        sleep_len(0, n);
        chk("R2 idle cycles to sleep", n, 5);
        chk("R8 fn1 stays awake", int'(fn_pd[1]), 0);
        window(c0, c1);
        chk("R6 clock low asleep", c0, 0);

        // R4: wake with recovery 3
        wr(1'b0, 2'd2, 16'd3);
        @(negedge clk); acc[0] = 1'b1;
        #1;
        chk("R4 wait same cycle", int'(wait_s), 1);
        wait_len(n);
        chk("R4 wait length", n, 5);
        chk("R4 awake after recovery", int'(fn_pd[0]), 0);

        // R3: access coincides with timeout expiry
        @(negedge clk); acc[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 not asleep at T-1", int'(fn_pd[0]), 0);
        acc[0] = 1'b1;
        @(negedge clk);
        chk("R3 pd stays low", int'(fn_pd[0]), 0);
        chk("R3 no wait", int'(wait_s), 0);
        acc[0] = 1'b0;
        sleep_len(0, n);
        chk("R3 full timeout again", n, 5);

        // R7: forced power-down on function 1
        wr(1'b1, 2'd0, 16'h0020);
        @(negedge clk);
        chk("R7 forced pd", int'(fn_pd[1]), 1);
        acc[1] = 1'b1;
        repeat (6) begin
            @(negedge clk); #1;
            chk("R7 access ignored wait", int'(wait_s), 0);
            chk("R7 access ignored pd", int'(fn_pd[1]), 1);
        end
        acc[1] = 1'b0;
        wr(1'b1, 2'd0, 16'd0);
        @(negedge clk);
        chk("R7 stays asleep after clear", int'(fn_pd[1]), 1);
        acc[1] = 1'b1;
        wait_len(n);
        chk("R7 default recovery wake", n, 6);
        @(negedge clk); acc[1] = 1'b0;

        // R9: address 3 is ignored
        wr(1'b1, 2'd3, 16'hFFFF);
        window(c0, c1);
        chk("R9 clk1 unchanged", c1, 64);
        chk("R9 pd1 unchanged", int'(fn_pd[1]), 0);

        // R10: both wake together, recoveries 3 and 7
        wr(1'b1, 2'd2, 16'd7);
        wr(1'b1, 2'd0, 16'h0020);
        wr(1'b1, 2'd0, 16'd0);
        chk("R10 both asleep", int'(fn_pd), 3);
        @(negedge clk); acc = 2'b11;
        wait_len(n);
        chk("R10 wait spans slowest", n, 9);
        chk("R10 both awake", int'(fn_pd), 0);
        @(negedge clk); acc = 2'b00;
        wr(1'b0, 2'd0, 16'd0);

        // R2: zero timeout never sleeps
        wr(1'b0, 2'd1, 16'd0);
        wr(1'b0, 2'd0, 16'd1);
        repeat (40) @(negedge clk);
        chk("R2 zero timeout", int'(fn_pd[0]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule